// File: doc/BRIEF.md
# Embedded-Clock Serializer Channel

This block is one transmit lane of a parallel-to-serial link. It runs on the bit clock. A slot counter divides the bit clock into word periods of 20 bit times. In the last slot of each period the block captures an 18-bit parallel word. It then shifts that word out over the next 20 cycles, framed by a start bit and a stop bit. The start bit guarantees one rising edge per frame, which the receiver recovers as the embedded clock.

The framed payload is chosen once per word period, by a fixed priority among the control inputs:

- power-down, which is immediate, quiets the lane and drops lock;
- output disable keeps the lock;
- a lock-acquisition counter sends the alignment pattern after reset or power-up;
- a sync request sends the alignment pattern;
- a PRBS-15 self-test source replaces the data;
- otherwise the parallel data is sent.

A 3-bit pre-emphasis level is registered with each frame for the output driver.

Top module: `emb_ser_chan`

## Requirements
- R1: `word_tick` is high in the last slot of each 20-cycle word period, and `din` is captured at the clock edge that ends that slot. The first serial bit of that word appears on `ser_out` in the next cycle, and slot k follows k cycles later.
- R2: A driven frame is, in transmission order: a 1, then the 18 payload bits with bit 0 first, then a 0. It is sent with `ser_oe` high for all 20 slots.
- R3: Output disable (`out_en` low at the capture edge) makes the whole frame undriven, with `ser_oe` low and `ser_out` low. The lock counter keeps running and keeps its state, so data resumes in the next frame once enable returns.
- R4: When the alignment pattern is sent, the payload bits 0 to 8 are 1 and bits 9 to 17 are 0 (payload 18'h001FF), and `din` has no effect on the frame.
- R5: `pwr_run` low clears the lane in the next cycle: `ser_oe` low, `ser_out` low, `locked` low, `pem_lvl` 0. The lock is lost.
- R6: After reset or after `pwr_run` returns high, the first LOCK_WORDS frames with power on (default 512, to be set within 510 to 1024) send the alignment pattern. They are driven when enabled, whatever `sync_req`, `bist_sel` and `din` are. `locked` rises at the capture edge that ends the LOCK_WORDS-th such frame.
- R7: The payload is chosen by priority, highest first: power-down, disable, lock in progress, sync request, self-test, parallel data.
- R8: Self-test payload: a 15-bit register s shifts left and takes in s[14] XOR s[13] (x^15 + x^14 + 1). Payload bit k is the bit taken in at step k+1, and each frame advances 18 steps. s is reloaded to 15'h7FFF by every frame that is not a self-test frame, so the first self-test frame after any other frame starts from that seed.
- R9: `pem_lvl` is loaded at each capture edge. It is `pem_sel` (binary 0 to 7, 0 meaning none) for a driven frame and 0 for an undriven frame.
- R10: While `rst` is high, `ser_oe`, `ser_out`, `locked` and `pem_lvl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 18 | Parallel word to serialize |
| pwr_run | input | 1 | Low selects power-down |
| out_en | input | 1 | Low disables the serial output |
| sync_req | input | 1 | Requests the alignment pattern |
| bist_sel | input | 1 | Selects the PRBS-15 self-test payload |
| pem_sel | input | 3 | Pre-emphasis level request |
| word_tick | output | 1 | High in the capture slot of each word period |
| ser_out | output | 1 | Serial bitstream |
| ser_oe | output | 1 | Serial driver enable |
| locked | output | 1 | Lock acquisition complete |
| pem_lvl | output | 3 | Registered pre-emphasis level for the driver |

## Verification
Every frame result is due one cycle after the capture edge marked by `word_tick`, and slot k of that frame is due k cycles after that. The bench drives inputs at the falling edge in the capture slot and samples `ser_out`, `ser_oe` and `pem_lvl` on the next 20 falling edges. `locked` is due at the capture edge, so it is compared at the falling edge that starts the next capture slot. Power-down acts in the cycle after it is seen. The bench keeps it stable across a whole frame, so every slot of that frame is expected quiet.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;

    localparam int DATA_W  = 18;
    localparam int FRAME_W = DATA_W + 2;
    localparam int SLOT_W  = $clog2(FRAME_W);
    localparam int PRBS_W  = 15;
    localparam int PEM_W   = 3;

    typedef enum logic [2:0] {
        MODE_OFF  = 3'd0,
        MODE_DIS  = 3'd1,
        MODE_LOCK = 3'd2,
        MODE_SYNC = 3'd3,
        MODE_BIST = 3'd4,
        MODE_DATA = 3'd5
    } tx_mode_e;

    typedef struct packed {
        logic pwr_ok;
        logic out_en;
        logic locked;
        logic sync_req;
        logic bist_sel;
    } ctrl_t;

    typedef struct packed {
        logic               drive;
        logic [FRAME_W-1:0] bits;
    } frame_t;

    // Priority resolution, highest first.
    function automatic tx_mode_e pick_mode(ctrl_t c);
        tx_mode_e m;
        if (!c.pwr_ok)        m = MODE_OFF;
        else if (!c.out_en)   m = MODE_DIS;
        else if (!c.locked)   m = MODE_LOCK;
        else if (c.sync_req)  m = MODE_SYNC;
        else if (c.bist_sel)  m = MODE_BIST;
        else                  m = MODE_DATA;
        return m;
    endfunction

    // Alignment payload: lower half ones, upper half zeros.
    function automatic logic [DATA_W-1:0] align_word();
        logic [DATA_W-1:0] w;
        for (int i = 0; i < DATA_W; i++) w[i] = (i < DATA_W/2);
        return w;
    endfunction

    function automatic logic [PRBS_W-1:0] prbs_step(logic [PRBS_W-1:0] s);
        return {s[PRBS_W-2:0], s[PRBS_W-1] ^ s[PRBS_W-2]};
    endfunction

    function automatic logic [DATA_W-1:0] prbs_fill(logic [PRBS_W-1:0] s);
        logic [DATA_W-1:0] w;
        logic [PRBS_W-1:0] t;
        t = s;
        for (int k = 0; k < DATA_W; k++) begin
            t    = prbs_step(t);
            w[k] = t[0];
        end
        return w;
    endfunction

    function automatic logic [PRBS_W-1:0] prbs_adv(logic [PRBS_W-1:0] s);
        logic [PRBS_W-1:0] t;
        t = s;
        for (int k = 0; k < DATA_W; k++) t = prbs_step(t);
        return t;
    endfunction

    function automatic frame_t make_frame(tx_mode_e m, logic [DATA_W-1:0] payload);
        frame_t f;
        f.drive = (m != MODE_OFF) && (m != MODE_DIS);
        f.bits  = f.drive ? {1'b0, payload, 1'b1} : '0;
        return f;
    endfunction

endpackage

// File: rtl/ser_slot_ctr.sv
`timescale 1ns/1ps
module ser_slot_ctr
    import ser_pkg::*;
#(
    parameter int SLOTS = FRAME_W,
    localparam int CW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] slot,
    output logic          last
);
    localparam logic [CW-1:0] LAST_SLOT = CW'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst)                slot <= '0;
        else if (slot == LAST_SLOT) slot <= '0;
        else                    slot <= slot + 1'b1;
    end

    assign last = (slot == LAST_SLOT);

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        slot <= LAST_SLOT) else $error("slot counter out of range"); // R1

endmodule

// File: rtl/ser_lock_ctr.sv
`timescale 1ns/1ps
module ser_lock_ctr #(
    parameter int LOCK_WORDS = 512,
    localparam int CNT_W     = $clog2(LOCK_WORDS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic tick,
    output logic locked
);
    localparam logic [CNT_W-1:0] DONE = CNT_W'(LOCK_WORDS);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwr_ok)          cnt <= '0;
        else if (tick && cnt != DONE) cnt <= cnt + 1'b1;
    end

    assign locked = (cnt == DONE);

    AST_LOCK_KEPT: assert property (@(posedge clk) disable iff (rst)
        (locked && pwr_ok) |=> locked) else $error("lock lost while powered"); // R3

    AST_LOCK_STEP: assert property (@(posedge clk) disable iff (rst)
        (!tick && pwr_ok) |=> $stable(cnt)) else $error("lock count moved off tick"); // R6

endmodule

// File: rtl/ser_prbs15.sv
`timescale 1ns/1ps
module ser_prbs15
    import ser_pkg::*;
#(
    parameter logic [PRBS_W-1:0] SEED = 15'h7FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              advance,
    output logic [DATA_W-1:0] word
);
    logic [PRBS_W-1:0] state;

    always_ff @(posedge clk) begin
        if (rst || restart) state <= SEED;
        else if (advance)   state <= prbs_adv(state);
    end

    assign word = prbs_fill(state);

    AST_PRBS_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state != '0) else $error("prbs register reached zero"); // R8

endmodule

// File: rtl/ser_shifter.sv
`timescale 1ns/1ps
module ser_shifter
    import ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_ok,
    input  logic             load,
    input  frame_t           frame_in,
    input  logic [PEM_W-1:0] pem_in,
    output logic             ser_out,
    output logic             drive,
    output logic [PEM_W-1:0] pem_out
);
    logic [FRAME_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst || !pwr_ok) begin
            sh      <= '0;
            drive   <= 1'b0;
            pem_out <= '0;
        end else if (load) begin
            sh      <= frame_in.bits;
            drive   <= frame_in.drive;
            pem_out <= frame_in.drive ? pem_in : '0;
        end else begin
            sh      <= sh >> 1;
        end
    end

    assign ser_out = sh[0];

    AST_QUIET_WHEN_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        !drive |-> (!ser_out && pem_out == '0)) else $error("undriven lane not quiet"); // R3

endmodule

// File: rtl/emb_ser_chan.sv
`timescale 1ns/1ps
module emb_ser_chan
    import ser_pkg::*;
#(
    parameter int                LOCK_WORDS = 512,
    parameter logic [PRBS_W-1:0] PRBS_SEED  = 15'h7FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              pwr_run,
    input  logic              out_en,
    input  logic              sync_req,
    input  logic              bist_sel,
    input  logic [PEM_W-1:0]  pem_sel,
    output logic              word_tick,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              locked,
    output logic [PEM_W-1:0]  pem_lvl
);
    logic [SLOT_W-1:0] slot;
    logic              last;
    logic [DATA_W-1:0] prbs_word;
    logic [DATA_W-1:0] payload;
    ctrl_t             ctrl;
    tx_mode_e          mode;
    frame_t            frame;

    ser_slot_ctr #(.SLOTS(FRAME_W)) u_slot (
        .clk  (clk),
        .rst  (rst),
        .slot (slot),
        .last (last)
    );

    ser_lock_ctr #(.LOCK_WORDS(LOCK_WORDS)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .pwr_ok (pwr_run),
        .tick   (last),
        .locked (locked)
    );

    always_comb begin
        ctrl.pwr_ok   = pwr_run;
        ctrl.out_en   = out_en;
        ctrl.locked   = locked;
        ctrl.sync_req = sync_req;
        ctrl.bist_sel = bist_sel;
        mode          = pick_mode(ctrl);
        case (mode)
            MODE_LOCK, MODE_SYNC: payload = align_word();
            MODE_BIST:            payload = prbs_word;
            MODE_DATA:            payload = din;
            default:              payload = '0;
        endcase
        frame = make_frame(mode, payload);
    end

    ser_prbs15 #(.SEED(PRBS_SEED)) u_prbs (
        .clk     (clk),
        .rst     (rst),
        .restart (!pwr_run || (last && mode != MODE_BIST)),
        .advance (last && mode == MODE_BIST),
        .word    (prbs_word)
    );

    ser_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .pwr_ok   (pwr_run),
        .load     (last),
        .frame_in (frame),
        .pem_in   (pem_sel),
        .ser_out  (ser_out),
        .drive    (ser_oe),
        .pem_out  (pem_lvl)
    );

    assign word_tick = last;

    AST_START_SLOT: assert property (@(posedge clk) disable iff (rst)
        (slot == '0 && ser_oe) |-> ser_out) else $error("start bit missing"); // R2

    AST_STOP_SLOT: assert property (@(posedge clk) disable iff (rst)
        (last && ser_oe) |-> !ser_out) else $error("stop bit missing"); // R2

    AST_OE_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (slot != '0 && pwr_run && $past(pwr_run)) |-> $stable(ser_oe)) else $error("oe moved mid-frame"); // R3

    AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
        !pwr_run |=> (!ser_oe && !locked && pem_lvl == '0)) else $error("power-down not quiet"); // R5

    AST_LOCKING_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (last && !locked && pwr_run && out_en) |=> (ser_oe && ser_out)) else $error("locking frame not driven"); // R6

endmodule

// File: tb/emb_ser_chan_tb.sv
`timescale 1ns/1ps
module emb_ser_chan_tb;

    localparam int DW    = 18;
    localparam int FW    = DW + 2;
    localparam int NLOCK = 512;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] din;
    logic          pwr_run, out_en, sync_req, bist_sel;
    logic [2:0]    pem_sel;
    logic          word_tick, ser_out, ser_oe, locked;
    logic [2:0]    pem_lvl;

    int checks = 0;
    int fails  = 0;

    // bench models
    int         m_lock = 0;
    logic [14:0] m_prbs = 15'h7FFF;

    always #2 clk = ~clk;

    emb_ser_chan u_dut (
        .clk(clk), .rst(rst), .din(din), .pwr_run(pwr_run), .out_en(out_en),
        .sync_req(sync_req), .bist_sel(bist_sel), .pem_sel(pem_sel),
        .word_tick(word_tick), .ser_out(ser_out), .ser_oe(ser_oe),
        .locked(locked), .pem_lvl(pem_lvl)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // 0 off,1 dis,2 lock,3 sync,4 bist,5 data
    function automatic int exp_mode(bit p, bit e, bit s, bit b, int lk);
        if (!p) return 0;
        if (!e) return 1;
        if (lk < NLOCK) return 2;
        if (s) return 3;
        if (b) return 4;
        return 5;
    endfunction

    function automatic logic [14:0] lfsr(logic [14:0] s);
        return {s[13:0], s[14] ^ s[13]};
    endfunction

    task automatic frame(input bit p, input bit e, input bit s, input bit b,
                         input logic [DW-1:0] d, input logic [2:0] pem, input string req);
        int            md;
        logic [DW-1:0] pay;
        logic [FW-1:0] exp_bits, got_bits;
        bit            exp_oe, oe_ok;
        logic [2:0]    got_pem;
        while (!word_tick) @(negedge clk);
        pwr_run = p; out_en = e; sync_req = s; bist_sel = b; din = d; pem_sel = pem;
        md = exp_mode(p, e, s, b, m_lock);
        pay = '0;
        if (md == 2 || md == 3) pay = 18'h001FF;
        if (md == 5) pay = d;
        if (md == 4) begin
            for (int k = 0; k < DW; k++) begin
                m_prbs = lfsr(m_prbs);
                pay[k] = m_prbs[0];
            end
        end else begin
            m_prbs = 15'h7FFF;
        end
        if (!p) m_lock = 0;
        else if (m_lock < NLOCK) m_lock++;
        exp_oe   = (md >= 2);
        exp_bits = exp_oe ? {1'b0, pay, 1'b1} : '0;
        oe_ok    = 1'b1;
        got_pem  = '0;
        for (int i = 0; i < FW; i++) begin
            @(negedge clk);
            got_bits[i] = ser_out;
            if (ser_oe !== exp_oe) oe_ok = 1'b0;
            if (i == 0) got_pem = pem_lvl;
        end
        check(oe_ok, req, "oe over frame", 32'(ser_oe), 32'(exp_oe));
        check(got_bits === exp_bits, req, "frame bits", 32'(got_bits), 32'(exp_bits));
        check(got_pem === (exp_oe ? pem : 3'd0), "R9", "pem level", 32'(got_pem),
              32'(exp_oe ? pem : 3'd0));
        check(locked === (m_lock >= NLOCK), "R6", "locked", 32'(locked), 32'(m_lock >= NLOCK));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; din = '0; pwr_run = 1'b1; out_en = 1'b1;
        sync_req = 1'b0; bist_sel = 1'b0; pem_sel = 3'd0;
        repeat (4) @(negedge clk);
        // R10 reset state
        check(ser_oe === 1'b0, "R10", "oe in reset", 32'(ser_oe), 0);
        check(ser_out === 1'b0, "R10", "out in reset", 32'(ser_out), 0);
        check(locked === 1'b0, "R10", "locked in reset", 32'(locked), 0);
        check(pem_lvl === 3'd0, "R10", "pem in reset", 32'(pem_lvl), 0);
        rst = 1'b0;

        // R6 lock phase after reset; self-test, sync and data are overridden, R3 disable on top
        for (int n = 0; n < NLOCK; n++)
            frame(1'b1, ($urandom % 8) != 0, $urandom % 2, $urandom % 2,
                  DW'($urandom), 3'($urandom), "R6");

        // R1 R2 directed data patterns
        frame(1, 1, 0, 0, 18'h00000, 3'd0, "R2");
        frame(1, 1, 0, 0, 18'h3FFFF, 3'd7, "R2");
        frame(1, 1, 0, 0, 18'h2AAAA, 3'd3, "R1");
        frame(1, 1, 0, 0, 18'h00001, 3'd1, "R1");
        frame(1, 1, 0, 0, 18'h20000, 3'd5, "R1");
        // R4 sync ignores din; R7 sync beats self-test
        frame(1, 1, 1, 0, 18'h3FFFF, 3'd2, "R4");
        frame(1, 1, 1, 1, 18'h12345, 3'd2, "R7");
        // R8 self-test continuity and reseed
        for (int n = 0; n < 5; n++) frame(1, 1, 0, 1, 18'h3C3C3, 3'd4, "R8");
        frame(1, 1, 0, 0, 18'h0F0F0, 3'd4, "R8");
        frame(1, 1, 0, 1, 18'h0F0F0, 3'd4, "R8");
        // R3 disable keeps lock, data next frame; R7 disable beats sync
        frame(1, 0, 0, 0, 18'h15555, 3'd6, "R3");
        frame(1, 0, 1, 1, 18'h15555, 3'd6, "R7");
        frame(1, 1, 0, 0, 18'h15555, 3'd6, "R3");

        // random mix, no power-down
        for (int n = 0; n < 300; n++)
            frame(1'b1, ($urandom % 10) != 0, ($urandom % 7) == 0, ($urandom % 3) == 0,
                  DW'($urandom), 3'($urandom), "R7");

        // R5 power-down, then relock
        frame(0, 1, 0, 0, 18'h3FFFF, 3'd7, "R5");
        frame(0, 1, 1, 1, 18'h3FFFF, 3'd7, "R5");
        for (int n = 0; n < NLOCK; n++)
            frame(1'b1, ($urandom % 8) != 0, $urandom % 2, $urandom % 2,
                  DW'($urandom), 3'($urandom), "R6");
        frame(1, 1, 0, 0, 18'h2D2D2, 3'd1, "R6");
        frame(1, 1, 0, 1, 18'h2D2D2, 3'd1, "R8");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule